// File: doc/BRIEF.md
# Vertical Sync Period Meter

This block measures the interval between successive vertical sync pulses of a display input. A prescaler divides the system clock into a fixed 8 µs time base. A 12-bit counter advances on each tick of that time base, and on every accepted rising edge of the sync input its value is latched into a read-only period register. Multiplying the latched value by 8 µs gives the frame period. The counter restarts from zero on the same edge, so consecutive frames are measured with no gap.

The raw sync pin first passes through a two-flop synchronizer and a digital pulse-width filter. The filter accepts a new level only after it has stayed stable for `FILT_CYC` clocks, which covers 125 ns at the system clock. Shorter pulses of either polarity have no effect. If no sync arrives, the counter stops at its maximum value and a sticky overflow flag rises. A single-cycle clear strobe from the host drops the flag, zeroes the counter and starts a new measurement.

Top module: `vsync_period_meter`

## Requirements
- R1: While reset is asserted, and after it is released, `period_o` reads 0 and `ovf_o` reads 0 until an event changes them.
- R2: The internal count advances by one on each time-base tick. A tick occurs once every `TICK_DIV` clocks and is free-running from reset.
- R3: On each accepted rising edge of the filtered sync, `period_o` loads the current count. At all other times `period_o` holds its value.
- R4: The count restarts from zero on the capturing edge. Sync edges spaced exactly N ticks apart therefore give identical consecutive captures.
- R5: When a tick arrives while the count is at 4095, `ovf_o` goes high. It stays high, across later captures as well, until a clear strobe.
- R6: A sync level that lasts fewer than `FILT_CYC` clocks, whether high or low, is ignored. A level that holds for `FILT_CYC` clocks is accepted.
- R7: The count saturates at 4095 and does not wrap, so a capture taken after an overflow loads 4095.
- R8: A one on `ovf_clr` clears `ovf_o` and the count in the next cycle. Counting then restarts, so the next capture measures from the clear.
- R9: When a clear and an accepted rising edge fall in the same cycle, the clear wins and `period_o` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vsync_in | input | 1 | Raw vertical sync, active-high |
| ovf_clr | input | 1 | Single-cycle write-one clear of the overflow flag; also restarts the count |
| period_o | output | 12 | Last captured period, in time-base ticks |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `ovf_clr` is synchronous to `clk`. They also assume that `vsync_in` can change at any cycle, since the synchronizer and filter absorb its timing, and that the sync polarity has already been made active-high. The stimulus drives every input on the falling clock edge and pulses the clear strobe for exactly one cycle. It mixes sub-threshold glitches of both levels with legal pulses, so that the filter boundary is tested from both sides without breaking those assumptions. The bench uses a short prescaler ratio, so the 12-bit overflow is reached within the run.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  // Default geometry of the measurement path
  localparam int unsigned PERIOD_W_DEF = 12;
  localparam int unsigned TICK_DIV_DEF = 400; // 8 us at 50 MHz
  localparam int unsigned FILT_CYC_DEF = 7;   // >= 125 ns at 50 MHz

  // Priority of the counter update in one cycle
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_CLEAR   = 2'd1,
    UPD_CAPTURE = 2'd2,
    UPD_TICK    = 2'd3
  } upd_e;
endpackage

// File: rtl/vpm_tick_gen.sv
module vpm_tick_gen #(
  parameter int unsigned TICK_DIV = vpm_pkg::TICK_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          wrap;

  always_comb begin
    wrap  = (div_q == LAST);
    div_d = wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = wrap;

  // R2: one tick, then the divider starts a fresh interval
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (div_q == '0));
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/vpm_sync_filter.sv
module vpm_sync_filter #(
  parameter int unsigned FILT_CYC = vpm_pkg::FILT_CYC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

  logic          meta_q, sync_q;
  logic          lvl_q, lvl_d, lvl_dly_q;
  logic [CW-1:0] run_q, run_d;
  logic          differs;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  // pulse-width filter: next state
  always_comb begin
    differs = (sync_q != lvl_q);
    lvl_d   = lvl_q;
    run_d   = '0;
    if (differs) begin
      if (run_q == LIMIT) begin
        lvl_d = sync_q;
        run_d = '0;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      lvl_dly_q <= 1'b0;
      run_q     <= '0;
    end else begin
      lvl_q     <= lvl_d;
      lvl_dly_q <= lvl_q;
      run_q     <= run_d;
    end
  end

  assign rise_o = lvl_q & ~lvl_dly_q;

  // R6: the filtered level only moves once the synchronized input has disagreed long enough
  p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!differs || run_q != LIMIT) |=> (lvl_q == $past(lvl_q)));
  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vpm_period_counter.sv
module vpm_period_counter
  import vpm_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rise_i,
  input  logic                clr_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                ovf_o
);
  localparam logic [PERIOD_W-1:0] CNT_MAX = {PERIOD_W{1'b1}};

  logic [PERIOD_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic                ovf_q, ovf_d;
  upd_e                upd;

  always_comb begin
    if (clr_i)       upd = UPD_CLEAR;
    else if (rise_i) upd = UPD_CAPTURE;
    else if (tick_i) upd = UPD_TICK;
    else             upd = UPD_HOLD;
  end

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    ovf_d = ovf_q;
    unique case (upd)
      UPD_CLEAR: begin
        cnt_d = '0;
        ovf_d = 1'b0;
      end
      UPD_CAPTURE: begin
        per_d = cnt_q;
        cnt_d = '0;
      end
      UPD_TICK: begin
        if (cnt_q == CNT_MAX) ovf_d = 1'b1;
        else                  cnt_d = cnt_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      ovf_q <= ovf_d;
    end
  end

  assign period_o = per_q;
  assign ovf_o    = ovf_q;

  // R5: sticky flag
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);
  // R5/R7: tick at the ceiling raises the flag and the count stays put
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && tick_i && !rise_i && !clr_i) |=> (ovf_q && cnt_q == CNT_MAX));
  // R8: clear restarts the measurement
  p_clear_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !ovf_q));
  // R3/R9: period only moves on an unpreempted capture
  p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i || clr_i) |=> $stable(per_q));
  // R4: counting restarts from zero on capture
  p_capture_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/vsync_period_meter.sv
module vsync_period_meter #(
  parameter int unsigned TICK_DIV = vpm_pkg::TICK_DIV_DEF,
  parameter int unsigned FILT_CYC = vpm_pkg::FILT_CYC_DEF,
  parameter int unsigned PERIOD_W = vpm_pkg::PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsync_in,
  input  logic                ovf_clr,
  output logic [PERIOD_W-1:0] period_o,
  output logic                ovf_o
);
  logic rst_meta_q, rst_int_n;
  logic tick, rise;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  vpm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  vpm_sync_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  (vsync_in),
    .rise_o (rise)
  );

  vpm_period_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick),
    .rise_i   (rise),
    .clr_i    (ovf_clr),
    .period_o (period_o),
    .ovf_o    (ovf_o)
  );

  // R1: outputs idle while the block is held in reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_int_n |-> (period_o == '0 && !ovf_o));
endmodule

// File: tb/vsync_period_meter_tb_top.sv
module vsync_period_meter_tb_top;
  localparam int TDIV = 4;
  localparam int FCYC = 3;
  localparam int W    = 12;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0;
  logic ovf_clr = 1'b0;
  logic [W-1:0] period_o;
  logic ovf_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vsync_period_meter #(.TICK_DIV(TDIV), .FILT_CYC(FCYC), .PERIOD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .ovf_clr(ovf_clr),
    .period_o(period_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_rel;         // cycles since external reset release
  int  m_pre;         // clocks into current tick interval
  int  m_ticks;       // ticks counted since last restart
  int  m_per;
  bit  m_ovf;
  bit  syn_q[$];      // synchronizer delay line
  bit  m_lvl, m_lvl_prev;
  int  m_same;        // clocks the synchronized level has disagreed

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_pre = 0; m_ticks = 0; m_per = 0; m_ovf = 0;
      syn_q = '{0, 0}; m_lvl = 0; m_lvl_prev = 0; m_same = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit edge_seen, tick_now, s;
      edge_seen = m_lvl && !m_lvl_prev;
      tick_now  = (m_pre == TDIV - 1);
      if (ovf_clr) begin
        m_ticks = 0; m_ovf = 0;
      end else if (edge_seen) begin
        m_per = m_ticks; m_ticks = 0;
      end else if (tick_now) begin
        if (m_ticks >= MAXC) m_ovf = 1;
        else m_ticks++;
      end
      m_pre = tick_now ? 0 : m_pre + 1;
      m_lvl_prev = m_lvl;
      s = syn_q[0];
      if (s != m_lvl) begin
        m_same++;
        if (m_same >= FCYC) begin m_lvl = s; m_same = 0; end
      end else m_same = 0;
      void'(syn_q.pop_front());
      syn_q.push_back(vsync_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk("model period", int'(period_o) == m_per, int'(period_o), m_per);
      chk("model ovf", ovf_o == m_ovf, int'(ovf_o), int'(m_ovf));
      if (cyc > 190000) begin
        chk("watchdog", 1'b0, cyc, 190000);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic pulse(input int high_cyc, input int low_cyc);
    @(negedge clk) vsync_in = 1'b1;
    repeat (high_cyc) @(negedge clk);
    vsync_in = 1'b0;
    repeat (low_cyc) @(negedge clk);
  endtask

  initial begin
    int p1, p2, hold;
    repeat (3) @(negedge clk);
    chk("R1 reset period", period_o == 0, int'(period_o), 0);
    chk("R1 reset ovf", ovf_o == 0, int'(ovf_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 after release", period_o == 0 && !ovf_o, int'(period_o), 0);

    // R2/R3/R4: edges 400 clocks apart = 100 ticks
    pulse(20, 379);
    pulse(20, 379);
    p1 = int'(period_o);
    chk("R2 period 100 ticks", p1 >= 99 && p1 <= 101, p1, 100);
    pulse(20, 379);
    p2 = int'(period_o);
    chk("R4 gapless equal periods", p2 == p1, p2, p1);
    // different spacing: 200 clocks = 50 ticks
    pulse(20, 179);
    pulse(20, 179);
    chk("R3 period 50 ticks", period_o == 50, int'(period_o), 50);

    // R6: short high glitch ignored
    hold = int'(period_o);
    @(negedge clk) vsync_in = 1'b1;
    repeat (FCYC - 1) @(negedge clk);
    vsync_in = 1'b0;
    repeat (40) @(negedge clk);
    chk("R6 short high ignored", int'(period_o) == hold, int'(period_o), hold);
    // R6: short low dropout inside a pulse does not make a second edge
    @(negedge clk) vsync_in = 1'b1;
    repeat (20) @(negedge clk);
    hold = int'(period_o);
    vsync_in = 1'b0;
    repeat (FCYC - 1) @(negedge clk);
    vsync_in = 1'b1;
    repeat (30) @(negedge clk);
    chk("R6 short low ignored", int'(period_o) == hold, int'(period_o), hold);
    vsync_in = 1'b0;
    repeat (30) @(negedge clk);
    // R6: exactly FCYC wide is accepted
    pulse(FCYC, 40);
    chk("R6 minimum pulse accepted", int'(period_o) == m_per && m_per < hold + 40,
        int'(period_o), m_per);

    // R5/R7: no sync until overflow
    repeat ((MAXC + 2) * TDIV + 50) @(negedge clk);
    chk("R5 overflow set", ovf_o == 1, int'(ovf_o), 1);
    pulse(20, 100);
    chk("R7 saturated capture", period_o == MAXC, int'(period_o), MAXC);
    chk("R5 ovf sticky after capture", ovf_o == 1, int'(ovf_o), 1);

    // R8: clear restarts the measurement
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R8 ovf cleared", ovf_o == 0, int'(ovf_o), 0);
    repeat (199) @(negedge clk);
    pulse(20, 50);
    p1 = int'(period_o);
    chk("R8 measures from clear", p1 >= 49 && p1 <= 52, p1, 50);

    // R9: clear coincides with accepted edge
    hold = int'(period_o);
    repeat (100) @(negedge clk);
    vsync_in = 1'b1;
    repeat (5) @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    repeat (30) @(negedge clk);
    vsync_in = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 clear wins over capture", int'(period_o) == hold, int'(period_o), hold);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule